// File: doc/BRIEF.md
# Channel Gain Scaler with Ramp Profile

This block is the output gain stage of one transmit channel. Every valid I/Q sample is multiplied by a 12-bit gain mantissa. The product is then divided by a power of two chosen by a 4-bit shift count. The result is rounded and clipped to the output width. Both lanes use the same gain and shift.

In profile mode, a 64-entry ramp table scales the gain further. The table index walks up one entry per valid sample while transmit enable is high, and walks down one entry per valid sample while it is low. This gives a smooth power-up and power-down instead of a hard switch. When the index sits at the bottom with transmit enable low, the channel is silent. A hold control freezes the index. Hold must be set before the table can be written.

Top module: `gain_ramp_scaler`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` is 0 and both outputs are 0. The gain is 1024 (unity), the shift is 0, profile mode is off, hold is off, every table entry is 0 and the ramp index is 0.
- R2: `out_valid` rises exactly two clock cycles after the sample was presented with `in_valid` high, and is low otherwise. The output words hold their last value while `out_valid` is low.
- R3: With profile mode off and `tx_en` high, each output is `round(x * G / 2^(10 + S))`. G is the unsigned 12-bit gain, where 1024 means unity, and S is the 4-bit shift. A `cfg_we` pulse loads gain, shift, profile mode and hold together. The new values apply to samples presented after that edge.
- R4: Rounding is to nearest with ties toward positive infinity, so +1.5 becomes 2 and -1.5 becomes -1.
- R5: Results above 2^(OW-1)-1 or below -2^(OW-1) are clipped to those bounds.
- R6: With profile mode off, a sample presented while `tx_en` is low gives 0 on both lanes, with `out_valid` still asserted.
- R7: With profile mode on, the effective gain is `floor(G * P / 4096)`. P is the unsigned 12-bit table entry at the ramp index in force when the sample is presented.
- R8: With profile mode on and hold off, each valid sample moves the index after it is used. The index goes up by one if `tx_en` is high and the index is below 63. It goes down by one if `tx_en` is low and the index is above 0. A `tx_en` reversal mid-ramp turns the ramp back from the current index. Cycles without a valid sample do not move the index.
- R9: With profile mode on, a sample presented while `tx_en` is low and the index is 0 gives 0 on both lanes.
- R10: While hold is set, the ramp index does not move. A `prof_we` write reaches the table only while hold is set, and is ignored otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample present on `in_i`/`in_q` |
| in_i | input | 16 | In-phase sample, two's complement |
| in_q | input | 16 | Quadrature sample, two's complement |
| tx_en | input | 1 | Transmit enable level |
| cfg_we | input | 1 | Load the four configuration fields |
| cfg_gain | input | 12 | Gain mantissa, 1024 = unity |
| cfg_shift | input | 4 | Extra right shift |
| cfg_prof_en | input | 1 | Enable ramp profile mode |
| cfg_hold | input | 1 | Freeze ramp index, allow table writes |
| prof_we | input | 1 | Table write strobe |
| prof_addr | input | 6 | Table write address |
| prof_data | input | 12 | Table entry, 4096 = unity |
| out_valid | output | 1 | Scaled sample present |
| out_i | output | 16 | Scaled in-phase sample |
| out_q | output | 16 | Scaled quadrature sample |

## Verification
A wrong ramp index does not stay hidden for long. It changes the scale of the very next valid output, two cycles after that sample enters. Over a full ramp it also shifts the point where output falls to zero by the size of the error. A wrong table entry or a missed hold shows as a one-sample step in amplitude at the index that uses it. The reference model steps its own index and compares both lanes on every clock, so a discrepancy is reported in the cycle it reaches the ports.

// File: rtl/gs_pkg.sv
// Package: shared types for the channel gain scaler.
// Assumes: nothing beyond IEEE 1800-2017.
package gs_pkg;

    // Direction the ramp index takes at the next edge.
    typedef enum logic [1:0] {
        MOVE_STAY = 2'b00,
        MOVE_UP   = 2'b01,
        MOVE_DOWN = 2'b10
    } ramp_move_e;

endpackage

// File: rtl/gs_prof_ram.sv
// Module: gs_prof_ram
// Holds the ramp profile: DEPTH unsigned entries of PW bits.
// It has one synchronous write port and one combinational read port.
// Assumes: the write enable is already qualified by the caller.
module gs_prof_ram #(
    parameter int DEPTH = 64,
    parameter int PW    = 12,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [PW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [PW-1:0] rdata
);

    logic [PW-1:0] mem [DEPTH];

    // Clear every entry on reset, otherwise store the qualified write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) begin
                mem[k] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Asynchronous read of the entry selected by the ramp index.
    always_comb begin
        rdata = mem[raddr];
    end

endmodule

// File: rtl/gs_ramp_ctrl.sv
// Module: gs_ramp_ctrl
// Steps the ramp index once per valid sample: up while transmit enable
// is high, down while it is low, and never while hold is set.
// It also decides whether the current sample must be silenced.
// Assumes: step is high for exactly the cycles that carry a sample.
module gs_ramp_ctrl
    import gs_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          prof_en,
    input  logic          hold,
    input  logic          tx_en,
    output logic [AW-1:0] idx,
    output logic          silence
);

    localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

    ramp_move_e move;

    // Choose the index move for this cycle.
    always_comb begin
        move = MOVE_STAY;
        if (step && prof_en && !hold) begin
            if (tx_en && (idx != TOP)) begin
                move = MOVE_UP;
            end else if (!tx_en && (idx != '0)) begin
                move = MOVE_DOWN;
            end
        end
    end

    // Apply the chosen move to the index register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else begin
            case (move)
                MOVE_UP:   idx <= idx + 1'b1;
                MOVE_DOWN: idx <= idx - 1'b1;
                default:   idx <= idx;
            endcase
        end
    end

    // Silence rule: a bottomed-out ramp in profile mode, or a plain low enable otherwise.
    always_comb begin
        if (prof_en) begin
            silence = !tx_en && (idx == '0);
        end else begin
            silence = !tx_en;
        end
    end

endmodule

// File: rtl/gs_lane.sv
// Module: gs_lane
// One arithmetic lane in two stages. Stage one forms the signed product of
// the sample and the unsigned gain. Stage two rounds half up, shifts right by
// (GW-2 + shift) and clips to OW bits.
// Assumes: the product width is larger than OW, and the shift is captured
// together with the sample it belongs to.
module gs_lane #(
    parameter int DW = 16,
    parameter int OW = 16,
    parameter int GW = 12,
    parameter int SW = 4,
    localparam int FRAC   = GW - 2,
    localparam int PROD_W = DW + GW + 1,
    localparam int ACC_W  = PROD_W + 1,
    localparam int TW     = $clog2(FRAC + (1 << SW)) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 zero,
    input  logic signed [DW-1:0] sample,
    input  logic        [GW-1:0] gain,
    input  logic        [SW-1:0] shift,
    input  logic                 ld1,
    output logic signed [OW-1:0] result
);

    localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((1 << (OW - 1)) - 1);
    localparam logic signed [ACC_W-1:0] MINV = -MAXV - 1;

    logic signed [PROD_W-1:0] xe, ge, prod_d, prod_q;
    logic        [SW-1:0]     sh_q;
    logic        [TW-1:0]     tot;
    logic        [ACC_W-1:0]  half;
    logic signed [ACC_W-1:0]  acc, shifted;
    logic signed [OW-1:0]     clip;

    // Stage one operand widening and multiply.
    always_comb begin
        xe     = PROD_W'(sample);
        ge     = $signed(PROD_W'(gain));
        prod_d = xe * ge;
    end

    // Stage one register: product (or zero when silenced) and its shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q <= '0;
            sh_q   <= '0;
        end else if (load) begin
            prod_q <= zero ? '0 : prod_d;
            sh_q   <= shift;
        end
    end

    // Stage two: add half an LSB, arithmetic shift, clip.
    always_comb begin
        tot     = TW'(FRAC) + TW'(sh_q);
        half    = ACC_W'(1) << (tot - TW'(1));
        acc     = {prod_q[PROD_W-1], prod_q} + $signed(half);
        shifted = acc >>> tot;
        if (shifted > MAXV) begin
            clip = MAXV[OW-1:0];
        end else if (shifted < MINV) begin
            clip = MINV[OW-1:0];
        end else begin
            clip = shifted[OW-1:0];
        end
    end

    // Output register updates only when stage one held a sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
        end else if (ld1) begin
            result <= clip;
        end
    end

endmodule

// File: rtl/gs_scale_pipe.sv
// Module: gs_scale_pipe
// Forms the effective gain, which is the static mantissa or the mantissa
// scaled by the profile entry. It carries the valid flag through two stages
// and runs one gs_lane per I/Q component.
// Assumes: the profile entry is already the one for the current index.
module gs_scale_pipe #(
    parameter int DW = 16,
    parameter int OW = 16,
    parameter int GW = 12,
    parameter int SW = 4,
    parameter int PW = 12,
    localparam int NL = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_i,
    input  logic signed [DW-1:0] in_q,
    input  logic        [GW-1:0] gain,
    input  logic        [SW-1:0] shift,
    input  logic                 prof_en,
    input  logic        [PW-1:0] prof_val,
    input  logic                 silence,
    output logic                 out_valid,
    output logic signed [OW-1:0] out_i,
    output logic signed [OW-1:0] out_q
);

    logic        [GW+PW-1:0] gp;
    logic        [GW-1:0]    eff_gain;
    logic                    v1_q;
    logic signed [DW-1:0]    lane_in  [NL];
    logic signed [OW-1:0]    lane_out [NL];

    // Effective gain: profile entry scales the mantissa, with truncation.
    always_comb begin
        gp       = (GW + PW)'(gain) * (GW + PW)'(prof_val);
        eff_gain = prof_en ? GW'(gp >> PW) : gain;
    end

    // Valid flag through both stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1_q      <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            v1_q      <= in_valid;
            out_valid <= v1_q;
        end
    end

    // Lane routing.
    always_comb begin
        lane_in[0] = in_i;
        lane_in[1] = in_q;
        out_i      = lane_out[0];
        out_q      = lane_out[1];
    end

    for (genvar k = 0; k < NL; k++) begin : g_lane
        gs_lane #(
            .DW(DW), .OW(OW), .GW(GW), .SW(SW)
        ) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (in_valid),
            .zero   (silence),
            .sample (lane_in[k]),
            .gain   (eff_gain),
            .shift  (shift),
            .ld1    (v1_q),
            .result (lane_out[k])
        );
    end

endmodule

// File: rtl/gain_ramp_scaler.sv
// Module: gain_ramp_scaler (top)
// Per-channel output gain stage. It holds the configuration registers and
// joins the profile table, the ramp controller and the two-stage scaling
// pipeline. Latency from sample to output is two cycles.
// Assumes: software sets hold before writing the table.
module gain_ramp_scaler #(
    parameter int DW    = 16,
    parameter int OW    = 16,
    parameter int GW    = 12,
    parameter int SW    = 4,
    parameter int PW    = 12,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_i,
    input  logic signed [DW-1:0] in_q,
    input  logic                 tx_en,
    input  logic                 cfg_we,
    input  logic        [GW-1:0] cfg_gain,
    input  logic        [SW-1:0] cfg_shift,
    input  logic                 cfg_prof_en,
    input  logic                 cfg_hold,
    input  logic                 prof_we,
    input  logic        [AW-1:0] prof_addr,
    input  logic        [PW-1:0] prof_data,
    output logic                 out_valid,
    output logic signed [OW-1:0] out_i,
    output logic signed [OW-1:0] out_q
);

    localparam logic [GW-1:0] UNITY = GW'(1 << (GW - 2));

    logic [GW-1:0] gain_q;
    logic [SW-1:0] shift_q;
    logic          prof_en_q;
    logic          hold_q;
    logic [AW-1:0] ramp_idx;
    logic [PW-1:0] prof_val;
    logic          silence;
    logic          ram_we;

    // Configuration registers, all loaded by one strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gain_q    <= UNITY;
            shift_q   <= '0;
            prof_en_q <= 1'b0;
            hold_q    <= 1'b0;
        end else if (cfg_we) begin
            gain_q    <= cfg_gain;
            shift_q   <= cfg_shift;
            prof_en_q <= cfg_prof_en;
            hold_q    <= cfg_hold;
        end
    end

    // Table writes are honoured only while the ramp is frozen.
    always_comb begin
        ram_we = prof_we && hold_q;
    end

    gs_prof_ram #(.DEPTH(DEPTH), .PW(PW)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ram_we),
        .waddr (prof_addr),
        .wdata (prof_data),
        .raddr (ramp_idx),
        .rdata (prof_val)
    );

    gs_ramp_ctrl #(.DEPTH(DEPTH)) u_ramp (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (in_valid),
        .prof_en (prof_en_q),
        .hold    (hold_q),
        .tx_en   (tx_en),
        .idx     (ramp_idx),
        .silence (silence)
    );

    gs_scale_pipe #(
        .DW(DW), .OW(OW), .GW(GW), .SW(SW), .PW(PW)
    ) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_i      (in_i),
        .in_q      (in_q),
        .gain      (gain_q),
        .shift     (shift_q),
        .prof_en   (prof_en_q),
        .prof_val  (prof_val),
        .silence   (silence),
        .out_valid (out_valid),
        .out_i     (out_i),
        .out_q     (out_q)
    );

endmodule

// File: rtl/gs_checker.sv
// Module: gs_checker
// Temporal properties of gain_ramp_scaler, attached with bind.
// Assumes: reset is held low from time zero.
module gs_checker #(
    parameter int AW = 6,
    parameter int OW = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 tx_en,
    input logic                 prof_en,
    input logic                 hold,
    input logic [AW-1:0]        idx,
    input logic                 out_valid,
    input logic signed [OW-1:0] out_i,
    input logic signed [OW-1:0] out_q
);

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);                                   // R2
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid);                                 // R2
    AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(out_i) && $stable(out_q)));            // R2
    AST_TX_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !prof_en && !tx_en) |-> ##2 (out_i == '0 && out_q == '0)); // R6
    AST_IDX_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (idx != $past(idx)) |-> ((idx == $past(idx) + 1'b1) || ($past(idx) == idx + 1'b1))); // R8
    AST_IDX_IDLE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(idx));                                   // R8
    AST_MUTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && prof_en && !tx_en && idx == '0) |-> ##2 (out_i == '0 && out_q == '0)); // R9
    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(idx));                                        // R10

endmodule

bind gain_ramp_scaler gs_checker #(.AW(AW), .OW(OW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .tx_en     (tx_en),
    .prof_en   (prof_en_q),
    .hold      (hold_q),
    .idx       (ramp_idx),
    .out_valid (out_valid),
    .out_i     (out_i),
    .out_q     (out_q)
);

// File: tb/gain_ramp_scaler_bench.sv
module gain_ramp_scaler_bench;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_i = '0, in_q = '0;
    logic               tx_en = 1'b0;
    logic               cfg_we = 1'b0;
    logic        [11:0] cfg_gain = '0;
    logic        [3:0]  cfg_shift = '0;
    logic               cfg_prof_en = 1'b0, cfg_hold = 1'b0;
    logic               prof_we = 1'b0;
    logic        [5:0]  prof_addr = '0;
    logic        [11:0] prof_data = '0;
    logic               out_valid;
    logic signed [15:0] out_i, out_q;

    int    checks = 0;
    int    errors = 0;
    string cur_tag = "R1";
    bit    cmp_on = 1'b0;

    always #5 clk = ~clk;

    gain_ramp_scaler u_gain_ramp_scaler (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .tx_en(tx_en), .cfg_we(cfg_we), .cfg_gain(cfg_gain), .cfg_shift(cfg_shift),
        .cfg_prof_en(cfg_prof_en), .cfg_hold(cfg_hold), .prof_we(prof_we),
        .prof_addr(prof_addr), .prof_data(prof_data),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    // Reference model state
    int m_gain, m_shift, m_idx;
    bit m_pen, m_hold;
    int m_ram [64];
    bit p_v, o_v;
    int p_i, p_q, o_i, o_q;
    int eff;
    bit sil;

    function automatic int ref_scale(int x, int g, int s);
        longint v;
        int tot;
        tot = 10 + s;
        v = longint'(x) * longint'(g);
        v = (v + (longint'(1) <<< (tot - 1))) >>> tot;
        if (v > 32767) v = 32767;
        if (v < -32768) v = -32768;
        return int'(v);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_gain = 1024; m_shift = 0; m_pen = 0; m_hold = 0; m_idx = 0;
            foreach (m_ram[k]) m_ram[k] = 0;
            p_v = 0; o_v = 0; p_i = 0; p_q = 0; o_i = 0; o_q = 0;
        end else begin
            o_v = p_v;
            if (p_v) begin o_i = p_i; o_q = p_q; end
            p_v = in_valid;
            if (in_valid) begin
                eff = m_pen ? (m_gain * m_ram[m_idx]) / 4096 : m_gain;
                sil = m_pen ? (!tx_en && m_idx == 0) : !tx_en;
                p_i = sil ? 0 : ref_scale(int'(in_i), eff, m_shift);
                p_q = sil ? 0 : ref_scale(int'(in_q), eff, m_shift);
                if (m_pen && !m_hold) begin
                    if (tx_en && m_idx < 63) m_idx++;
                    else if (!tx_en && m_idx > 0) m_idx--;
                end
            end
            if (prof_we && m_hold) m_ram[prof_addr] = int'(prof_data);
            if (cfg_we) begin
                m_gain = int'(cfg_gain); m_shift = int'(cfg_shift);
                m_pen = cfg_prof_en; m_hold = cfg_hold;
            end
            cmp_on = 1'b1;
        end
    end

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    // Compare against the model on every clock (R2 for valid, phase tag for data).
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            chk("R2", int'(out_valid), int'(o_v));
            chk(cur_tag, int'(out_i), o_i);
            chk(cur_tag, int'(out_q), o_q);
        end
    end

    task automatic report;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic send(input int i, input int q);
        @(negedge clk);
        in_valid = 1'b1; in_i = 16'(i); in_q = 16'(q);
    endtask

    task automatic gap(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (n - 1) @(negedge clk);
    endtask

    task automatic cfgw(input int g, input int s, input bit pe, input bit h);
        @(negedge clk);
        in_valid = 1'b0; cfg_we = 1'b1;
        cfg_gain = 12'(g); cfg_shift = 4'(s); cfg_prof_en = pe; cfg_hold = h;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pwrite(input int a, input int d);
        @(negedge clk);
        in_valid = 1'b0; prof_we = 1'b1; prof_addr = 6'(a); prof_data = 12'(d);
        @(negedge clk);
        prof_we = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", int'(out_valid), 0);
        chk("R1", int'(out_i), 0);
        chk("R1", int'(out_q), 0);
        rst_n = 1'b1;
        tx_en = 1'b1;

        // R1 / R3: default unity gain passes samples through
        cur_tag = "R3";
        send(1234, -777);
        gap(2);
        chk("R1", int'(out_i), 1234);
        chk("R3", int'(out_q), -777);
        send(32767, -32768); send(-1, 1); gap(3);

        // R3: non-unity gain and shift over a varied pattern
        cfgw(3000, 2, 0, 0);
        for (int k = 0; k < 40; k++) begin
            send((k * 7919) % 65536 - 32768, (k * 4111) % 65536 - 32768);
            if (k % 7 == 3) gap(2);
        end
        gap(3);

        // R4: ties round toward +infinity
        cur_tag = "R4";
        cfgw(1024, 1, 0, 0);
        send(3, -3);
        gap(2);
        chk("R4", int'(out_i), 2);
        chk("R4", int'(out_q), -1);

        // R5: clipping at both bounds
        cur_tag = "R5";
        cfgw(4095, 0, 0, 0);
        send(32767, -32768);
        gap(2);
        chk("R5", int'(out_i), 32767);
        chk("R5", int'(out_q), -32768);

        // R6: enable low with profile off silences output
        cur_tag = "R6";
        tx_en = 1'b0;
        send(5000, -5000);
        gap(2);
        chk("R6", int'(out_i), 0);
        chk("R6", int'(out_valid), 1);

        // R10: load table under hold, then an unheld write must be ignored
        cur_tag = "R10";
        cfgw(2048, 1, 1, 1);
        for (int k = 0; k < 64; k++) pwrite(k, 64 * k + 63);
        cfgw(2048, 1, 1, 0);
        pwrite(0, 0);

        // R7 / R8: ramp up from index 0
        cur_tag = "R7";
        tx_en = 1'b1;
        send(10000, -10000);
        gap(2);
        chk("R10", int'(out_i), 151);
        for (int k = 0; k < 70; k++) begin
            send(10000, -6000);
            if (k % 9 == 4) gap(2);
        end

        // R8: falling, reversing, falling again
        cur_tag = "R8";
        tx_en = 1'b0;
        for (int k = 0; k < 20; k++) send(12000, 9000);
        tx_en = 1'b1;
        for (int k = 0; k < 5; k++) send(12000, 9000);

        // R10: hold freezes the index mid-ramp
        cur_tag = "R10";
        cfgw(2048, 1, 1, 1);
        tx_en = 1'b0;
        for (int k = 0; k < 6; k++) send(12000, 9000);
        cfgw(2048, 1, 1, 0);

        // R9: ramp down to the bottom, then mute
        cur_tag = "R9";
        for (int k = 0; k < 60; k++) send(12000, 9000);
        gap(2);
        send(20000, -20000);
        gap(2);
        chk("R9", int'(out_i), 0);
        chk("R9", int'(out_q), 0);
        gap(4);
        report();
    end

endmodule